// File: doc/BRIEF.md
# Key Event Queue with Freeze Handshake

This block collects qualified key press and release events from a keyboard matrix scanner and holds them in a 20-entry queue until a host collects them. Every stored event is a 32-bit word that carries the key index, a press/release flag and a frame-parity bit. The parity bit lets the host tell which events came from the same pass over the matrix.

The host does not read the queue at will. It first raises a freeze request and waits for an acknowledge, which arrives three scan clocks later. While the acknowledge is high, the host reads a 6-bit event count and pops entries one per read strobe. The count is the value latched at the last frame boundary. When the host drops the freeze with its clear bit held high, the queue, the count and the status flags all return to their empty state.

Events that arrive while the queue is full are discarded and raise an overflow flag. Their number is kept and added to the count at the first frame boundary after the next clear. A sticky keycode-present flag, and an interrupt gated by an enable, tell the host that events are waiting.

Top module: `keyevt_fifo`

## Requirements
- R1: A popped word has bit 31 = release flag (1 release, 0 press), bit 30 = frame parity, bits 7:0 = key index, and all other bits zero. Entries pop in arrival order.
- R2: All events that arrive in the same frame carry the same parity. That parity is the inverse of the parity of the last frame that had events. It is 1 for the first such frame after reset or clear. A frame with no events leaves the parity unchanged.
- R3: The queue holds 20 entries. An event that arrives while 20 are held is discarded and sets the sticky `stat_overflow`.
- R4: `host_cnt` is loaded, on the cycle `frozen_ack` rises, with the number of events accepted since the last clear as latched at the last `frame_end` (saturating at 63). At all other times it holds, except on a clear.
- R5: `frozen_ack` goes high on the third rising edge after `freeze_req` is first sampled high. It goes low on the third rising edge after `freeze_req` is first sampled low.
- R6: A clear happens only on the edge where `frozen_ack` falls while `clear_req` is high. It zeroes `host_cnt`, the latched count, both status flags, `irq`, the queue pointers and the parity history, and sets `rd_data` to 0x000000FF. Holding `clear_req` high without a freeze cycle, or unfreezing with `clear_req` low, changes nothing.
- R7: Discarded events are counted. At the first `frame_end` after a clear, that number is added to the running count.
- R8: `rd_pop` while `frozen_ack` is high pops one entry onto `rd_data` one cycle later. A pop on an empty queue returns 0x000000FF. `rd_pop` while `frozen_ack` is low leaves `rd_data` unchanged.
- R9: `stat_present` sets on the first accepted event. `irq` sets at that moment only if `int_en` is 1. Both stay set until a clear.
- R10: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Qualified event strobe |
| evt_up | input | 1 | 1 for release, 0 for press |
| evt_idx | input | 8 | Key index of the event |
| frame_end | input | 1 | Pulse at the end of a matrix pass |
| freeze_req | input | 1 | Host freeze request level |
| clear_req | input | 1 | Host clear bit, acted on at unfreeze |
| rd_pop | input | 1 | Host read strobe of the entry register |
| int_en | input | 1 | Interrupt enable |
| frozen_ack | output | 1 | Freeze acknowledge; reads valid while high |
| host_cnt | output | 6 | Event count visible to the host |
| rd_data | output | 32 | Last popped entry word |
| stat_present | output | 1 | Sticky: an event was queued |
| stat_overflow | output | 1 | Sticky: an event was discarded |
| irq | output | 1 | Sticky interrupt |

## Verification
Each result has a fixed due time. An accepted event shows on the status flags one edge after its strobe. A popped word appears on `rd_data` one edge after the read strobe. `frozen_ack` and the copy of the count arrive on the third edge after `freeze_req` changes, and a clear takes effect on the third edge after the freeze is dropped. The bench drives on falling edges and samples on the falling edge that follows the due edge. It checks `frozen_ack` one edge early as well, so that a wrong latency is caught in either direction. A sweep of every event count from 0 to 20 per frame, plus overflow, wrap-around and clear-ordering cases, is compared against a queue model that follows the requirements.

// File: rtl/keyevt_pkg.sv
package keyevt_pkg;

    localparam int IDX_W       = 8;
    localparam int WORD_W      = 32;
    localparam int SYNC_STAGES = 3;

    typedef struct packed {
        logic        up;
        logic        tog;
        logic [21:0] rsvd;
        logic [7:0]  idx;
    } kev_entry_t;

    function automatic kev_entry_t kev_fill();
        kev_entry_t e;
        e      = '0;
        e.idx  = 8'hFF;
        return e;
    endfunction

endpackage

// File: rtl/kev_freeze.sv
module kev_freeze
    import keyevt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic freeze_req,
    input  logic clear_req,
    output logic ack,
    output logic copy_pulse,
    output logic clr_pulse
);
    logic [SYNC_STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SYNC_STAGES-2:0], freeze_req};
    end

    assign ack        = sh[SYNC_STAGES-1];
    assign copy_pulse = sh[SYNC_STAGES-2] & ~sh[SYNC_STAGES-1];
    assign clr_pulse  = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES-2] & clear_req;

    // R5: acknowledge rises only after the request was seen three edges back
    a_r5_ack_lag: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(freeze_req, 3));
    a_r5_ack_drop: assert property (@(posedge clk) disable iff (rst)
        $fell(ack) |-> !$past(freeze_req, 3));
endmodule

// File: rtl/kev_store.sv
module kev_store
    import keyevt_pkg::*;
#(
    parameter int DEPTH = 20,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               ack,
    input  logic               push,
    input  kev_entry_t         push_entry,
    input  logic               pop,
    output logic               push_ok,
    output logic               drop,
    output logic [WORD_W-1:0]  rd_data
);
    kev_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [OCC_W-1:0] occ;
    logic             full, empty, pop_go, pop_real;

    assign full     = (occ == OCC_W'(DEPTH));
    assign empty    = (occ == '0);
    assign push_ok  = push & ~full & ~clr;
    assign drop     = push & full & ~clr;
    assign pop_go   = pop & ack & ~clr;
    assign pop_real = pop_go & ~empty;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= kev_fill();
            rd_data <= rst ? '0 : WORD_W'(kev_fill());
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= push_entry;
                wr_ptr      <= nxt(wr_ptr);
            end
            if (pop_go) begin
                if (!empty) begin
                    rd_data <= WORD_W'(mem[rd_ptr]);
                    rd_ptr  <= nxt(rd_ptr);
                end else begin
                    rd_data <= WORD_W'(kev_fill());
                end
            end
            occ <= occ + OCC_W'(push_ok) - OCC_W'(pop_real);
        end
    end

    // R3: occupancy never passes the capacity
    a_r3_occ_bound: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(DEPTH));
    // R8: no pop reaches the read word unless frozen
    a_r8_hold_unfrozen: assert property (@(posedge clk) disable iff (rst)
        (!ack && !clr) |=> $stable(rd_data));
endmodule

// File: rtl/kev_tally.sv
module kev_tally #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             frame_end,
    input  logic             evt,
    input  logic             push_ok,
    input  logic             drop,
    input  logic             copy,
    output logic             tog_now,
    output logic [CNT_W-1:0] host_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] acc, lost, bal, latched;
    logic [CNT_W-1:0] acc_n, lost_n;
    logic             tog_last, seen, seen_n;

    function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                                 input logic [CNT_W-1:0] b);
        logic [CNT_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CNT_W] ? CNT_MAX : s[CNT_W-1:0];
    endfunction

    assign acc_n   = sat_add(acc, CNT_W'(push_ok));
    assign lost_n  = sat_add(lost, CNT_W'(drop));
    assign seen_n  = seen | evt;
    assign tog_now = ~tog_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0; lost <= '0; bal <= '0; latched <= '0; host_cnt <= '0;
            tog_last <= 1'b0; seen <= 1'b0;
        end else if (clr) begin
            bal <= lost;
            acc <= '0; lost <= '0; latched <= '0; host_cnt <= '0;
            tog_last <= 1'b0; seen <= 1'b0;
        end else begin
            lost <= lost_n;
            if (frame_end) begin
                acc     <= sat_add(acc_n, bal);
                latched <= sat_add(acc_n, bal);
                bal     <= '0;
                seen    <= 1'b0;
                if (seen_n) tog_last <= ~tog_last;
            end else begin
                acc  <= acc_n;
                seen <= seen_n;
            end
            if (copy) host_cnt <= latched;
        end
    end

    // R4: host count moves only on a freeze copy or a clear
    a_r4_host_hold: assert property (@(posedge clk) disable iff (rst)
        (!copy && !clr) |=> $stable(host_cnt));
    // R2: parity holds across any cycle that is not a frame boundary
    a_r2_tog_frame: assert property (@(posedge clk) disable iff (rst)
        (!frame_end && !clr) |=> $stable(tog_now));
endmodule

// File: rtl/keyevt_fifo.sv
module keyevt_fifo
    import keyevt_pkg::*;
#(
    parameter int DEPTH = 20,
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic              evt_up,
    input  logic [IDX_W-1:0]  evt_idx,
    input  logic              frame_end,
    input  logic              freeze_req,
    input  logic              clear_req,
    input  logic              rd_pop,
    input  logic              int_en,
    output logic              frozen_ack,
    output logic [CNT_W-1:0]  host_cnt,
    output logic [WORD_W-1:0] rd_data,
    output logic              stat_present,
    output logic              stat_overflow,
    output logic              irq
);
    logic       copy_pulse, clr;
    logic       push_ok, drop, tog_now;
    kev_entry_t entry;

    assign entry = '{up: evt_up, tog: tog_now, rsvd: '0, idx: evt_idx};

    kev_freeze u_freeze (
        .clk(clk), .rst(rst), .freeze_req(freeze_req), .clear_req(clear_req),
        .ack(frozen_ack), .copy_pulse(copy_pulse), .clr_pulse(clr)
    );

    kev_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .clr(clr), .ack(frozen_ack),
        .push(evt_valid), .push_entry(entry), .pop(rd_pop),
        .push_ok(push_ok), .drop(drop), .rd_data(rd_data)
    );

    kev_tally #(.CNT_W(CNT_W)) u_tally (
        .clk(clk), .rst(rst), .clr(clr), .frame_end(frame_end),
        .evt(evt_valid & ~clr), .push_ok(push_ok), .drop(drop),
        .copy(copy_pulse), .tog_now(tog_now), .host_cnt(host_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            stat_present  <= 1'b0;
            stat_overflow <= 1'b0;
            irq           <= 1'b0;
        end else begin
            if (push_ok) stat_present <= 1'b1;
            if (push_ok && !stat_present && int_en) irq <= 1'b1;
            if (drop) stat_overflow <= 1'b1;
        end
    end

    // R9: interrupt only rises with the enable on
    a_r9_irq_en: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(int_en));
    // R3: overflow flag is sticky until a clear
    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (stat_overflow && !clr) |=> stat_overflow);
    // R6: a clear empties count and status
    a_r6_clear_all: assert property (@(posedge clk) disable iff (rst)
        clr |=> (host_cnt == '0 && !stat_present && !stat_overflow && !irq));
endmodule

// File: tb/keyevt_fifo_bench.sv
module keyevt_fifo_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid = 0, evt_up = 0, frame_end = 0;
    logic [7:0]  evt_idx = 0;
    logic        freeze_req = 0, clear_req = 0, rd_pop = 0, int_en = 0;
    logic        frozen_ack, stat_present, stat_overflow, irq;
    logic [5:0]  host_cnt;
    logic [31:0] rd_data;

    always #10 clk = ~clk;

    keyevt_fifo u_keyevt_fifo (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_up(evt_up),
        .evt_idx(evt_idx), .frame_end(frame_end), .freeze_req(freeze_req),
        .clear_req(clear_req), .rd_pop(rd_pop), .int_en(int_en),
        .frozen_ack(frozen_ack), .host_cnt(host_cnt), .rd_data(rd_data),
        .stat_present(stat_present), .stat_overflow(stat_overflow), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [31:0] m_q [64];
    int  m_head = 0, m_tail = 0, m_occ = 0;
    int  m_acc = 0, m_lost = 0, m_bal = 0, m_latched = 0, m_host = 0;
    bit  m_toglast = 0, m_seen = 0, m_present = 0, m_ovf = 0, m_irq = 0, m_frozen = 0;
    logic [31:0] m_rd = 32'h0;

    function automatic int sat(input int v);
        return (v > 63) ? 63 : v;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_status(input string tag);
        chk({tag, " present"}, 32'(stat_present), 32'(m_present));
        chk({tag, " overflow"}, 32'(stat_overflow), 32'(m_ovf));
        chk({tag, " irq"}, 32'(irq), 32'(m_irq));
    endtask

    task automatic push(input bit up, input int idx);
        logic [31:0] e;
        evt_valid = 1; evt_up = up; evt_idx = idx[7:0];
        step();
        evt_valid = 0;
        m_seen = 1;
        if (m_occ < 20) begin
            e = '0; e[31] = up; e[30] = ~m_toglast; e[7:0] = idx[7:0];
            m_q[m_tail % 64] = e; m_tail++; m_occ++;
            m_acc = sat(m_acc + 1);
            if (!m_present && int_en) m_irq = 1;
            m_present = 1;
        end else begin
            m_lost = sat(m_lost + 1);
            m_ovf = 1;
        end
    endtask

    task automatic frame();
        frame_end = 1; step(); frame_end = 0;
        if (m_seen) m_toglast = ~m_toglast;
        m_seen = 0;
        m_acc = sat(m_acc + m_bal); m_bal = 0;
        m_latched = m_acc;
    endtask

    task automatic freeze();
        freeze_req = 1;
        step(); step();
        chk("R5 ack still low", 32'(frozen_ack), 0);
        step();
        chk("R5 ack high", 32'(frozen_ack), 1);
        m_host = m_latched; m_frozen = 1;
        chk("R4 host count", 32'(host_cnt), 32'(m_host));
    endtask

    task automatic pop();
        rd_pop = 1; step(); rd_pop = 0;
        if (m_frozen) begin
            if (m_occ > 0) begin
                m_rd = m_q[m_head % 64]; m_head++; m_occ--;
            end else m_rd = 32'h0000_00FF;
        end
        chk("R1 R2 R8 entry word", rd_data, m_rd);
    endtask

    task automatic unfreeze(input bit c);
        clear_req = c; freeze_req = 0;
        step(); step();
        chk("R5 ack held", 32'(frozen_ack), 1);
        step();
        chk("R5 ack low", 32'(frozen_ack), 0);
        clear_req = 0; m_frozen = 0;
        if (c) begin
            m_bal = m_lost; m_lost = 0; m_occ = 0; m_head = m_tail;
            m_acc = 0; m_latched = 0; m_host = 0;
            m_present = 0; m_ovf = 0; m_irq = 0; m_toglast = 0; m_seen = 0;
            m_rd = 32'h0000_00FF;
        end
        chk("R6 host count after unfreeze", 32'(host_cnt), 32'(m_host));
        chk_status("R6");
        chk("R6 rd word after unfreeze", rd_data, m_rd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 0;
        step();
        // R10 reset state
        chk("R10 ack", 32'(frozen_ack), 0);
        chk("R10 count", 32'(host_cnt), 0);
        chk("R10 rd_data", rd_data, 0);
        chk_status("R10");

        // R1 R2 R9: frames with and without events
        int_en = 1;
        push(0, 5);
        chk_status("R9 first event");
        push(1, 9); push(0, 200);
        frame();
        frame();
        push(1, 77); push(0, 3);
        frame();
        pop();                     // R8 unfrozen read is ignored
        freeze();
        unfreeze(0);               // R6 no clear keeps state
        freeze();
        for (int k = 0; k < 6; k++) pop();
        unfreeze(1);

        // R6 clear bit alone has no effect; R4 count latched per frame
        clear_req = 1;
        push(0, 1);
        repeat (4) step();
        clear_req = 0;
        chk_status("R6 clear without freeze");
        push(1, 2);
        freeze();                  // R4 not yet latched
        unfreeze(0);
        frame();
        freeze();
        pop(); pop();
        unfreeze(1);

        // R3 overflow and R7 balance
        for (int k = 0; k < 23; k++) begin
            push(k[0], k * 7 + 1);
            if (k == 19) chk("R3 no overflow at 20", 32'(stat_overflow), 0);
            if (k == 20) chk("R3 overflow at 21", 32'(stat_overflow), 1);
        end
        frame();
        freeze();
        for (int k = 0; k < 21; k++) pop();
        unfreeze(1);
        frame();
        freeze();
        chk("R7 balance count", 32'(host_cnt), 3);
        pop();
        unfreeze(1);

        // R1 wrap-around with pushes while frozen
        for (int k = 0; k < 15; k++) push(k[1], 100 + k);
        frame();
        freeze();
        for (int k = 0; k < 10; k++) pop();
        for (int k = 0; k < 12; k++) push(~k[0], 30 + k);
        frame();
        for (int k = 0; k < 17; k++) pop();
        unfreeze(1);

        // sweep of every per-frame event count, R9 with enable patterns
        for (int n = 0; n <= 20; n++) begin
            int_en = (n % 3) != 0;
            for (int k = 0; k < n; k++) push((k + n) % 2 == 1, (n * 13 + k * 29) & 255);
            frame();
            chk_status("R9 sweep");
            freeze();
            for (int k = 0; k <= n; k++) pop();
            unfreeze(1);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule